// File: doc/BRIEF.md
# Clock Synthesizer Divider Calculator

This block turns a requested output clock period into the settings for a frequency synthesizer, whose output is the reference clock times two times a feedback divider, divided by the reference divider and a post divider. In the forward direction it takes the reference period, the reference divider and the target period. It forms an eight-times-scaled ratio q = floor(ref_per * ref_div * 4 / target). From q it picks a post-divider code and derives the feedback divider, or it flags the request as out of range.

In the reverse direction it takes a feedback divider and a post-divider code and returns the clock period those settings produce. Both directions share one serial restoring divider that yields one quotient bit per cycle. A `start_i` pulse taken while idle launches a calculation. `done_o` pulses for one cycle when the results are on the outputs, and the results stay there until the next calculation ends.

Top module: `pll_div_calc`

## Requirements
- R1: After reset, `done_o`, `range_err_o` and every result output are zero.
- R2: Forward mode (`mode_i`=0) computes q = floor(ref_per_i*ref_div_i*4/tgt_per_i), with all integer division truncating. When q<128 or q>2040, or when the target is 0, `range_err_o` is 1 and `post_code_o`, `post_val_o` and `fb_div_o` are 0. Otherwise `range_err_o` is 0.
- R3: In forward mode the post-divider code is [q<1024]+[q<512]+[q<256], so it lies in 0..3.
- R4: Post-divider values are looked up by code: 0→1, 1→2, 2→4, 3→8, 4→3. `post_val_o` is the value for `post_code_o`.
- R5: In forward mode `fb_div_o` = floor(q*post_val/8). For any accepted q it lies in 128..255.
- R6: Reverse mode (`mode_i`=1) sets `period_o` = floor(floor(ref_per_i*ref_div_i*P/fb_div_i)/2), where P is the value for `post_code_i` (codes 0..4, mapped as in R4). `range_err_o` is 0, and the forward outputs are 0.
- R7: In reverse mode, when `fb_div_i`=0 or `post_code_i`>4, `range_err_o` is 1 and `period_o` is 0.
- R8: `done_o` is high for exactly one cycle per accepted start. A `start_i` that arrives while a calculation is running is ignored, so it neither changes the result nor produces an extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calculation (taken only when idle) |
| mode_i | input | 1 | 0 forward (period to dividers), 1 reverse |
| ref_per_i | input | 32 | Reference clock period |
| ref_div_i | input | 8 | Reference divider |
| tgt_per_i | input | 32 | Requested output period (forward) |
| fb_div_i | input | 8 | Feedback divider (reverse) |
| post_code_i | input | 3 | Post-divider code (reverse) |
| post_code_o | output | 3 | Chosen post-divider code |
| post_val_o | output | 4 | Post-divide value for that code |
| fb_div_o | output | 8 | Feedback divider |
| period_o | output | 43 | Resulting period (reverse) |
| range_err_o | output | 1 | Request out of range |
| done_o | output | 1 | One-cycle result strobe |

## Verification
A corrupted partial remainder or quotient bit in the serial divider appears as a wrong q. That in turn shows up as a wrong code, a wrong feedback divider or a false range error, in the same cycle as the `done_o` of that calculation. The directed vectors place q exactly on and next to each threshold (127, 128, 255, 256, 511, 512, 1023, 1024, 2040, 2041), so a one-off error in the quotient or a wrong comparison flips a visible output. A stuck control state shows up either as a missing strobe within the bounded wait or as an extra strobe after a start issued mid-calculation.

// File: rtl/pll_calc_pkg.sv
`timescale 1ns/1ps
package pll_calc_pkg;
  localparam int unsigned SCALE_SH  = 3;    // ratio carried as 8x
  localparam int unsigned RATIO_MIN = 16;
  localparam int unsigned RATIO_MAX = 255;
  localparam int unsigned Q_MIN     = RATIO_MIN << SCALE_SH;
  localparam int unsigned Q_MAX     = RATIO_MAX << SCALE_SH;
  localparam int unsigned N_THR     = 3;
  localparam int unsigned CODE_MAX  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_FIN} calc_state_e;

  // non-monotonic code to value map
  function automatic logic [3:0] post_value(input logic [2:0] code);
    case (code)
      3'd0:    post_value = 4'd1;
      3'd1:    post_value = 4'd2;
      3'd2:    post_value = 4'd4;
      3'd3:    post_value = 4'd8;
      3'd4:    post_value = 4'd3;
      default: post_value = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pll_udiv.sv
`timescale 1ns/1ps
module pll_udiv #(
  parameter int unsigned N_W = 44,
  parameter int unsigned D_W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [N_W-1:0] quot_o,
  output logic           done_o
);
  localparam int unsigned CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   quot_q;
  logic [D_W-1:0]   rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [D_W:0]     trial;
  logic             fits;

  always_comb begin
    trial = {rem_q, quot_q[N_W-1]};
    fits  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        quot_q <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CNT_W'(N_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quot_q <= {quot_q[N_W-2:0], fits};
        rem_q  <= fits ? D_W'(trial - {1'b0, den_q}) : D_W'(trial);
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quot_q;

  // restoring step keeps remainder below divisor (truncating quotient, R2)
  p_rem_below_den_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/pll_post_sel.sv
`timescale 1ns/1ps
module pll_post_sel
  import pll_calc_pkg::*;
#(
  parameter int unsigned Q_W = 44
) (
  input  logic [Q_W-1:0] q_i,
  output logic [1:0]     code_o
);
  logic [N_THR-1:0] below;

  for (genvar k = 0; k < N_THR; k++) begin : g_thr
    assign below[k] = q_i < Q_W'(Q_MIN << (k + 1));
  end

  always_comb begin
    code_o = '0;
    for (int k = 0; k < N_THR; k++) code_o = code_o + 2'(below[k]);
  end
endmodule

// File: rtl/pll_div_calc.sv
`timescale 1ns/1ps
module pll_div_calc
  import pll_calc_pkg::*;
#(
  parameter int unsigned PER_W = 32,
  parameter int unsigned DIV_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     mode_i,
  input  logic [PER_W-1:0]         ref_per_i,
  input  logic [DIV_W-1:0]         ref_div_i,
  input  logic [PER_W-1:0]         tgt_per_i,
  input  logic [DIV_W-1:0]         fb_div_i,
  input  logic [2:0]               post_code_i,
  output logic [2:0]               post_code_o,
  output logic [3:0]               post_val_o,
  output logic [DIV_W-1:0]         fb_div_o,
  output logic [PER_W+DIV_W+2:0]   period_o,
  output logic                     range_err_o,
  output logic                     done_o
);
  localparam int unsigned NUM_W  = PER_W + DIV_W + 4;
  localparam int unsigned Q_KEEP = $clog2(Q_MAX + 1);
  localparam int unsigned PROD_W = Q_KEEP + 4;

  calc_state_e       state_q;
  logic              mode_q;
  logic [NUM_W-1:0]  base, div_num, quot;
  logic [PER_W-1:0]  div_den;
  logic              rev_bad, div_go, div_done, q_bad;
  logic [1:0]        code;
  logic [3:0]        pv_fwd;
  logic [PROD_W-1:0] fb_prod;

  always_comb begin
    base    = NUM_W'(ref_per_i) * NUM_W'(ref_div_i);
    div_num = mode_i ? base * NUM_W'(post_value(post_code_i)) : (base << 2);
    div_den = mode_i ? PER_W'(fb_div_i) : tgt_per_i;
    rev_bad = (fb_div_i == '0) || (post_code_i > 3'(CODE_MAX));
    div_go  = (state_q == ST_IDLE) && start_i && !(mode_i && rev_bad);
    q_bad   = (quot < NUM_W'(Q_MIN)) || (quot > NUM_W'(Q_MAX));
    pv_fwd  = post_value({1'b0, code});
    fb_prod = PROD_W'(quot[Q_KEEP-1:0]) * PROD_W'(pv_fwd);
  end

  pll_udiv #(.N_W(NUM_W), .D_W(PER_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .quot_o (quot),
    .done_o (div_done)
  );

  pll_post_sel #(.Q_W(NUM_W)) u_sel (
    .q_i   (quot),
    .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= 1'b0;
      post_code_o <= '0;
      post_val_o  <= '0;
      fb_div_o    <= '0;
      period_o    <= '0;
      range_err_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          state_q <= (mode_i && rev_bad) ? ST_FIN : ST_CALC;
        end
        ST_CALC: if (div_done) begin
          state_q     <= ST_IDLE;
          done_o      <= 1'b1;
          post_code_o <= '0;
          post_val_o  <= '0;
          fb_div_o    <= '0;
          period_o    <= '0;
          range_err_o <= 1'b0;
          if (mode_q) begin
            period_o <= (NUM_W-1)'(quot >> 1);
          end else if (q_bad) begin
            range_err_o <= 1'b1;
          end else begin
            post_code_o <= {1'b0, code};
            post_val_o  <= pv_fwd;
            fb_div_o    <= DIV_W'(fb_prod >> SCALE_SH);
          end
        end
        ST_FIN: begin
          state_q     <= ST_IDLE;
          done_o      <= 1'b1;
          post_code_o <= '0;
          post_val_o  <= '0;
          fb_div_o    <= '0;
          period_o    <= '0;
          range_err_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mode_q && !range_err_o) |-> (post_code_o <= 3'd3));
  p_fb_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mode_q && !range_err_o) |->
      (fb_div_o >= DIV_W'(Q_MIN) && fb_div_o <= DIV_W'(RATIO_MAX)));
  p_err_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && range_err_o) |-> (fb_div_o == '0 && post_val_o == '0));
  p_rev_err_period_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q && range_err_o) |-> (period_o == '0));
endmodule

// File: tb/pll_div_calc_bench.sv
`timescale 1ns/1ps
module pll_div_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0;
  logic [31:0] ref_per = '0, tgt_per = '0;
  logic [7:0]  ref_div = '0, fb_div = '0;
  logic [2:0]  pcode_in = '0;
  logic [2:0]  pcode_out;
  logic [3:0]  pval_out;
  logic [7:0]  fb_out;
  logic [42:0] period_out;
  logic        err_out, done_out;

  int n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;

  always #2 clk = ~clk;

  pll_div_calc u_pll_div_calc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .ref_per_i(ref_per), .ref_div_i(ref_div), .tgt_per_i(tgt_per),
    .fb_div_i(fb_div), .post_code_i(pcode_in),
    .post_code_o(pcode_out), .post_val_o(pval_out), .fb_div_o(fb_out),
    .period_o(period_out), .range_err_o(err_out), .done_o(done_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned pv_of(longint unsigned c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 3;
      default: return 0;
    endcase
  endfunction

  // launch one calculation, return 1 when done seen; outputs sampled there
  task automatic launch(bit m, output bit seen);
    @(negedge clk);
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_out) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic after_done(bit seen);
    chk("R8 done seen", seen, 1);
    @(negedge clk);
    chk("R8 done one cycle", done_out, 0);
  endtask

  task automatic run_fwd(longint unsigned rp, longint unsigned rd, longint unsigned tp);
    longint unsigned q, c, pv, fb;
    bit e, seen;
    ref_per = 32'(rp); ref_div = 8'(rd); tgt_per = 32'(tp);
    q  = (tp == 0) ? 64'hFFFF_FFFF : (rp * rd * 4) / tp;
    e  = (q < 128) || (q > 2040);
    c  = (q < 1024) + (q < 512) + (q < 256);
    pv = pv_of(c);
    fb = (q * pv) / 8;
    launch(1'b0, seen);
    chk("R2 range_err", err_out, e);
    chk("R3 post code", pcode_out, e ? 0 : c);
    chk("R4 post value", pval_out, e ? 0 : pv);
    chk("R5 fb divider", fb_out, e ? 0 : fb);
    after_done(seen);
  endtask

  task automatic run_rev(longint unsigned rp, longint unsigned rd,
                         longint unsigned fbv, longint unsigned code);
    longint unsigned per;
    bit e, seen;
    ref_per = 32'(rp); ref_div = 8'(rd); fb_div = 8'(fbv); pcode_in = 3'(code);
    e   = (fbv == 0) || (code > 4);
    per = e ? 0 : ((rp * rd * pv_of(code)) / fbv) / 2;
    launch(1'b1, seen);
    chk(e ? "R7 reverse err" : "R6 reverse err", err_out, e);
    chk(e ? "R7 period" : "R6 period", period_out, per);
    chk("R6 fb out zero", fb_out, 0);
    after_done(seen);
  endtask

  task automatic t_reset;
    chk("R1 done", done_out, 0);
    chk("R1 err", err_out, 0);
    chk("R1 fb", fb_out, 0);
    chk("R1 code", pcode_out, 0);
    chk("R1 period", period_out, 0);
  endtask

  task automatic t_fwd_codes;
    run_fwd(1000, 10, 40);   // q=1000 code 1
    run_fwd(1000, 10, 100);  // q=400 code 2
    run_fwd(1000, 10, 250);  // q=160 code 3
    run_fwd(1000, 10, 30);   // q=1333 code 0
    run_fwd(3579, 7, 123);   // irregular truncation
  endtask

  task automatic t_fwd_edges;
    longint unsigned qs[10] = '{127, 128, 255, 256, 511, 512, 1023, 1024, 2040, 2041};
    foreach (qs[i]) run_fwd(qs[i], 1, 4);
  endtask

  task automatic t_fwd_err;
    run_fwd(1000, 10, 0);    // zero target
    run_fwd(1000, 10, 19);   // too fast
    run_fwd(1000, 10, 400);  // too slow
  endtask

  task automatic t_rev;
    for (int c = 0; c <= 4; c++) run_rev(1000, 10, 200, longint'(c));
    run_rev(4127, 3, 137, 4);
  endtask

  task automatic t_rev_err;
    run_rev(1000, 10, 0, 1);
    run_rev(1000, 10, 200, 5);
    run_rev(1000, 10, 200, 7);
  endtask

  task automatic t_busy;
    bit seen;
    int extra;
    ref_per = 1000; ref_div = 10; tgt_per = 100;
    @(negedge clk);
    mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    tgt_per = 40; start = 1'b1;  // must be ignored
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_out) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R8 busy done", seen, 1);
    chk("R8 busy fb kept", fb_out, 200);
    chk("R8 busy code kept", pcode_out, 2);
    extra = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done_out) extra++;
    end
    chk("R8 no extra done", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_fwd_codes;
    t_fwd_edges;
    t_fwd_err;
    t_rev;
    t_rev_err;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule